// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block holds a 16-bit up-counter that advances on one of two clock-enable strobes. It expires when a selected tap of the counter is reached. In watchdog mode an expiry asks the system for a reset. In interval mode an expiry raises an interrupt flag, and that flag can drive an interrupt request. Software reaches the block through one 16-bit control word. A write takes effect only when the upper byte carries the access key. Any other upper byte counts as a security breach, and the block treats it exactly like a watchdog expiry.

The control word also holds two bits that configure an external interrupt pin. One bit enables the pin and the other chooses which edge triggers it. The block detects the chosen edge and reports it as a one-cycle event. On any reset request that the block raises itself, it returns its control word and counter to their defaults. The interrupt flag is kept through such a reset, so the cause can still be read afterwards. The flag is cleared only by an acknowledge or by the block's own asynchronous reset.

Top module: `keyed_watchdog`

## Requirements
- R1: A register write whose data bits 15:8 equal 0x5A loads bits 7:0 into the control byte. Reads return 0x69 in bits 15:8 and the control byte in bits 7:0. The restart bit (bit 3) always reads 0.
- R2: A register write whose bits 15:8 differ from 0x5A leaves the written byte unused. One cycle later, rst_req_o pulses, flag_o is set and the control byte returns to 0x00.
- R3: After rst_ni the control word reads 0x6900. This selects watchdog mode (bit 4 = 0), the 2^15 tap (bits 1:0 = 0) and the smclk_en_i source (bit 2 = 0).
- R4: Control bits 1:0 equal to 0, 1, 2 or 3 make the counter expire after 2^15, 2^13, 2^9 or 2^6 counted ticks from a restart.
- R5: Control bit 2 set to 0 counts cycles with smclk_en_i high, and set to 1 counts cycles with aclk_en_i high. The enable that is not selected has no effect.
- R6: A keyed write with bit 3 set restarts the counter at zero. This takes priority over a tick in the same cycle.
- R7: While control bit 7 (hold) is set, the counter keeps its value. No expiry occurs until hold is cleared.
- R8: In interval mode (bit 4 = 1), an expiry sets flag_o. irq_o is high exactly when flag_o is set, interval mode is selected, irq_en_i is high and gie_i is high. irq_ack_i clears flag_o.
- R9: In watchdog mode, an expiry makes rst_req_o high for one cycle and sets flag_o. It also clears the control byte to 0x00 and the counter. flag_o stays set until irq_ack_i arrives.
- R10: With control bit 5 set, nmi_evt_o pulses one cycle after an edge on nmi_pin_i. Control bit 6 set to 0 selects rising edges and set to 1 selects falling edges. With bit 5 clear, no event is produced.
- R11: In interval mode, expiries repeat every 2^tap ticks without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 1 | Control word addressed |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data, key in bits 15:8 |
| reg_rdata_o | output | 16 | Read data, zero when not reading |
| smclk_en_i | input | 1 | Fast source tick enable |
| aclk_en_i | input | 1 | Slow source tick enable |
| irq_en_i | input | 1 | Interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| nmi_pin_i | input | 1 | External interrupt pin |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Interval interrupt request |
| flag_o | output | 1 | Expiry / violation flag |
| nmi_evt_o | output | 1 | One-cycle pin edge event |

## Verification
All four taps are swept in interval mode, with the fast enable high every cycle and the slow enable held low. The measured tick counts separate the taps and show that the unselected source is ignored. Two taps are then repeated on a sparse slow-enable pattern while the fast enable is held high, which separates the two sources. The default watchdog expiry, a restart in mid-count, a hold in mid-count and a wrong key each give a distinct expected count or reset pulse. The pin-edge patterns cover both edge polarities with the pin function on and off.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_KEY = 8'h69;

  typedef struct packed {
    logic       hold;
    logic       nmi_fall;
    logic       nmi_on;
    logic       tmr_mode;
    logic       restart;
    logic       src_slow;
    logic [1:0] tap_sel;
  } ctrl_t;
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic        soft_rst_i,
  output ctrl_t       ctrl_o,
  output logic        restart_o,
  output logic        bad_key_o
);
  logic  key_ok;
  ctrl_t wr_val;

  assign key_ok    = (wdata_i[15:8] == WR_KEY);
  assign bad_key_o = wr_i && !key_ok;
  assign restart_o = wr_i && key_ok && wdata_i[3];

  always_comb begin
    wr_val         = ctrl_t'(wdata_i[7:0]);
    wr_val.restart = 1'b0;  // strobe bit, never stored
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_o <= '0;
    else if (soft_rst_i)       ctrl_o <= '0;
    else if (wr_i && key_ok)   ctrl_o <= wr_val;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 16,
  parameter int TAP_0 = 15,
  parameter int TAP_1 = 13,
  parameter int TAP_2 = 9,
  parameter int TAP_3 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [1:0]       tap_sel_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] mask;

  always_comb begin
    case (tap_sel_i)
      2'd0:    mask = (ONE << TAP_0) - ONE;
      2'd1:    mask = (ONE << TAP_1) - ONE;
      2'd2:    mask = (ONE << TAP_2) - ONE;
      default: mask = (ONE << TAP_3) - ONE;
    endcase
  end

  // expire on the tick that carries into the tap bit
  assign expire_o = tick_i && (&(cnt_o | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/kwdt_nmi_edge.sv
module kwdt_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic fall_i,
  output logic evt_o
);
  logic pin_q;
  logic hit;

  assign hit = fall_i ? (pin_q && !pin_i) : (!pin_q && pin_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      evt_o <= 1'b0;
    end else begin
      pin_q <= pin_i;
      evt_o <= en_i && hit;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP_0 = 15,
  parameter int TAP_1 = 13,
  parameter int TAP_2 = 9,
  parameter int TAP_3 = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_sel_i,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        smclk_en_i,
  input  logic        aclk_en_i,
  input  logic        irq_en_i,
  input  logic        gie_i,
  input  logic        irq_ack_i,
  input  logic        nmi_pin_i,
  output logic        rst_req_o,
  output logic        irq_o,
  output logic        flag_o,
  output logic        nmi_evt_o
);
  ctrl_t            ctrl_q;
  logic             wr;
  logic             restart;
  logic             bad_key;
  logic             expire;
  logic             soft_rst;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  assign wr       = reg_sel_i && reg_we_i;
  assign tick     = !ctrl_q.hold && (ctrl_q.src_slow ? aclk_en_i : smclk_en_i);
  assign soft_rst = bad_key || (expire && !ctrl_q.tmr_mode);

  kwdt_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .wdata_i    (reg_wdata_i),
    .soft_rst_i (soft_rst),
    .ctrl_o     (ctrl_q),
    .restart_o  (restart),
    .bad_key_o  (bad_key)
  );

  kwdt_counter #(
    .CNT_W (CNT_W),
    .TAP_0 (TAP_0),
    .TAP_1 (TAP_1),
    .TAP_2 (TAP_2),
    .TAP_3 (TAP_3)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .clr_i     (restart || soft_rst),
    .tap_sel_i (ctrl_q.tap_sel),
    .expire_o  (expire),
    .cnt_o     (cnt)
  );

  kwdt_nmi_edge u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (nmi_pin_i),
    .en_i   (ctrl_q.nmi_on),
    .fall_i (ctrl_q.nmi_fall),
    .evt_o  (nmi_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      rst_req_o <= soft_rst;
      if (expire || bad_key) flag_o <= 1'b1;
      else if (irq_ack_i)    flag_o <= 1'b0;
    end
  end

  assign irq_o       = flag_o && ctrl_q.tmr_mode && irq_en_i && gie_i;
  assign reg_rdata_o = (reg_sel_i && reg_re_i) ? {RD_KEY, ctrl_q} : 16'h0000;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [15:0]      wdata_i,
  input logic             hold_i,
  input logic             tmr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             rst_req_i,
  input logic             flag_i,
  input logic             irq_i,
  input logic             ack_i
);
  // R2
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[15:8] != 8'h5A) |=> (rst_req_i && flag_i));

  // R9
  req_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> flag_i);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flag_i && tmr_i));

  // R9
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !ack_i) |=> flag_i);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !wr_i) |=> $stable(cnt_i));

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[15:8] == 8'h5A && wdata_i[3]) |=> (cnt_i == '0));
endmodule

bind keyed_watchdog kwdt_chk #(.CNT_W(CNT_W)) u_kwdt_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr),
  .wdata_i   (reg_wdata_i),
  .hold_i    (ctrl_q.hold),
  .tmr_i     (ctrl_q.tmr_mode),
  .cnt_i     (cnt),
  .rst_req_i (rst_req_o),
  .flag_i    (flag_o),
  .irq_i     (irq_o),
  .ack_i     (irq_ack_i)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        smclk_en = 1'b1, aclk_en = 1'b0;
  logic        irq_en = 1'b0, gie = 1'b0, ack = 1'b0, nmi_pin = 1'b0;
  logic        rst_req, irq, flag, nmi_evt;

  int n_chk = 0;
  int n_bad = 0;
  int taps[4] = '{15, 13, 9, 6};

  always #10 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .smclk_en_i(smclk_en),
    .aclk_en_i(aclk_en), .irq_en_i(irq_en), .gie_i(gie), .irq_ack_i(ack),
    .nmi_pin_i(nmi_pin), .rst_req_o(rst_req), .irq_o(irq), .flag_o(flag),
    .nmi_evt_o(nmi_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    sel = 1'b1; we = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d);
    sel = 1'b1; re = 1'b1;
    #1 d = rdata;
    sel = 1'b0; re = 1'b0;
  endtask

  // acknowledge with both enables low so the ack edge adds no tick
  task automatic do_ack();
    ack = 1'b1; smclk_en = 1'b0; aclk_en = 1'b0;
    @(posedge clk); @(negedge clk);
    ack = 1'b0;
  endtask

  // count selected-source ticks until flag (or reset request) appears
  task automatic measure(input bit slow, input int period, input bit on_rst,
                         output int ticks);
    ticks = 0;
    for (int c = 0; c < 100000; c++) begin
      if (slow) begin aclk_en = (c % period == 0); smclk_en = 1'b1; end
      else      begin smclk_en = (c % period == 0); aclk_en = 1'b0; end
      @(posedge clk);
      if (slow ? aclk_en : smclk_en) ticks++;
      @(negedge clk);
      if (on_rst ? rst_req : flag) break;
    end
  endtask

  task automatic pin_step(input logic v, input logic exp, input string req);
    nmi_pin = v;
    @(posedge clk); @(negedge clk);
    check(req, nmi_evt, exp);
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    rd(d);
    check("R3 ctrl", d, 16'h6900);
    check("R3 rst_req", rst_req, 0);
    check("R3 flag", flag, 0);
    check("R3 irq", irq, 0);

    // R9 default watchdog expiry after 2^15 fast ticks
    irq_en = 1'b1; gie = 1'b1;
    measure(1'b0, 1, 1'b1, t);
    check("R9 R4 watchdog interval", t, 32768);
    check("R9 flag set", flag, 1);
    check("R9 no irq in watchdog", irq, 0);
    @(negedge clk);
    check("R9 one-cycle pulse", rst_req, 0);
    check("R9 flag kept", flag, 1);
    rd(d);
    check("R9 ctrl defaults", d, 16'h6900);
    do_ack();
    check("R9 ack clears", flag, 0);

    // R4 R5 R8 fast source sweep, slow enable held low
    for (int s = 0; s < 4; s++) begin
      wr(16'h5A18 | 16'(s));
      measure(1'b0, 1, 1'b0, t);
      check("R4 R5 fast tap", t, 1 << taps[s]);
      check("R8 irq raised", irq, 1);
      gie = 1'b0;
      #1 check("R8 gie gates irq", irq, 0);
      gie = 1'b1; irq_en = 1'b0;
      #1 check("R8 enable gates irq", irq, 0);
      irq_en = 1'b1;
      do_ack();
      check("R8 ack clears flag", flag, 0);
      check("R8 irq drops", irq, 0);
      if (s == 3) begin
        measure(1'b0, 1, 1'b0, t);
        check("R11 periodic", t, 64);
        do_ack();
      end
    end

    // R5 slow source, fast enable held high
    for (int s = 2; s < 4; s++) begin
      wr(16'h5A1C | 16'(s));
      measure(1'b1, 3, 1'b0, t);
      check("R5 slow tap", t, 1 << taps[s]);
      do_ack();
    end

    // R6 restart mid-count
    smclk_en = 1'b1; aclk_en = 1'b0;
    wr(16'h5A1B);
    repeat (40) @(negedge clk);
    wr(16'h5A1B);
    check("R6 no early flag", flag, 0);
    measure(1'b0, 1, 1'b0, t);
    check("R6 restart interval", t, 64);
    do_ack();

    // R7 hold mid-count
    smclk_en = 1'b1;
    wr(16'h5A1B);
    repeat (30) @(negedge clk);
    wr(16'h5A93);
    repeat (100) @(negedge clk);
    check("R7 held no flag", flag, 0);
    rd(d);
    check("R7 R1 readback", d, 16'h6993);
    wr(16'h5A13);
    measure(1'b0, 1, 1'b0, t);
    check("R7 remaining ticks", t, 33);
    do_ack();

    // R2 wrong key
    wr(16'hA51B);
    check("R2 reset request", rst_req, 1);
    check("R2 flag", flag, 1);
    rd(d);
    check("R2 ctrl cleared", d, 16'h6900);
    @(negedge clk);
    check("R2 pulse ends", rst_req, 0);
    do_ack();

    // R1 readback patterns
    wr(16'h5AFF); rd(d); check("R1 readback", d, 16'h69F7);
    wr(16'h5A5F); rd(d); check("R1 readback", d, 16'h6957);
    wr(16'h5AA7); rd(d); check("R1 readback", d, 16'h69A7);

    // R10 pin edges
    wr(16'h5AB0);
    pin_step(1'b1, 1'b1, "R10 rise");
    pin_step(1'b1, 1'b0, "R10 steady");
    pin_step(1'b0, 1'b0, "R10 fall ignored");
    wr(16'h5AF0);
    check("R10 polarity change", nmi_evt, 0);
    pin_step(1'b1, 1'b0, "R10 rise ignored");
    pin_step(1'b0, 1'b1, "R10 fall");
    wr(16'h5A90);
    pin_step(1'b1, 1'b0, "R10 off rise");
    pin_step(1'b0, 1'b0, "R10 off fall");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule